// File: doc/BRIEF.md
# Sequence-LRU Translation Lookaside Buffer

A fully associative address translation cache. Each entry maps one virtual page to a physical page base. Each entry carries its own page-size exponent, so one table can hold small and large pages together. Each entry also keeps a recency stamp, taken from a free-running sequence counter. Every stamp write takes the current counter value and then advances the counter. When the table is full, the entry with the oldest stamp is the one replaced.

One operation is presented per cycle on a shared request port, selected by `opCode`. The operations are lookup, insert, flush of every entry, flush of the non-global entries, and demap of a single page. A lookup answers one cycle later with a hit or a single-cycle miss pulse. A hit also returns the composed physical address, the uncacheable marking and the result of the privilege and write-protect checks. A refill source, such as a page walker, installs a complete entry with an insert.

Top module: `seq_lru_tlb`

## Requirements
- R1: After reset every entry is invalid, the sequence counter is 0, and all response outputs are 0. The first lookup misses.
- R2: A lookup (`opCode`=0) answers in the next cycle. It raises `rspValid` for one cycle together with exactly one of `rspHit` or `rspMiss`. `rspMiss` is a single-cycle pulse.
- R3: An entry matches when the virtual address agrees with its tag in every bit at or above the entry's page-size exponent. On a hit, `rspPaddr` is the entry's physical base OR'd with the virtual address bits below that exponent. When several entries match, the lowest index wins.
- R4: A lookup hit with `updateLru` set writes the current counter value into the hit entry's stamp and advances the counter. A lookup with `updateLru` clear changes no stamp and does not advance the counter.
- R5: An insert (`opCode`=1) whose address already matches a valid entry changes nothing: no entry is written and the counter does not advance.
- R6: An insert that matches no entry fills the lowest-indexed invalid entry. If every entry is valid, it replaces the entry with the smallest stamp, and the lowest index wins a tie.
- R7: A newly inserted entry takes the current counter value as its stamp, and the counter then advances by one. The counter is 32 bits wide.
- R8: A flush of non-global entries (`opCode`=3) invalidates every entry whose global bit is 0 and keeps the global entries.
- R9: A full flush (`opCode`=2) invalidates every entry.
- R10: A demap (`opCode`=4) invalidates the entry that matches the given address, if there is one. Otherwise nothing changes.
- R11: An access is user-level when `privLevel` is 3 and `forceSuper` is 0. A user-level hit on an entry without the user bit raises `rspFault`.
- R12: A bad write is a hit on an entry that is not writable, while either the access is user-level or `wpEnable` is set. A write, or a read with `storeCheck` set, that meets the bad-write condition raises `rspFault`. `rspFaultWrite` reports the fault as a write: it is set when the access is a write, or when the fault comes from the store-check condition alone.
- R13: `rspUncache` is 1 only for a hit without fault on an entry whose uncacheable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | 0 lookup, 1 insert, 2 flush all, 3 flush non-global, 4 demap |
| opVaddr | input | VA_W | Virtual address for lookup, insert or demap |
| updateLru | input | 1 | Lookup refreshes the hit entry's stamp |
| accWrite | input | 1 | Lookup is a write access |
| storeCheck | input | 1 | Read probe that must fault as a write would |
| privLevel | input | 2 | Current privilege level |
| forceSuper | input | 1 | Treat the access as supervisor regardless of level |
| wpEnable | input | 1 | Supervisor writes honour read-only pages |
| insPbase | input | PA_W | Physical page base of the inserted entry |
| insLogBytes | input | LB_W | Page-size exponent of the inserted entry |
| insGlobal | input | 1 | Inserted entry survives a non-global flush |
| insWritable | input | 1 | Inserted entry allows writes |
| insUser | input | 1 | Inserted entry is accessible at user level |
| insUncache | input | 1 | Inserted entry is uncacheable |
| rspValid | output | 1 | Lookup response present |
| rspHit | output | 1 | Lookup hit |
| rspMiss | output | 1 | Lookup miss pulse |
| rspFault | output | 1 | Page fault on the hit |
| rspFaultWrite | output | 1 | Fault reported as a write access |
| rspPaddr | output | PA_W | Translated physical address |
| rspUncache | output | 1 | Translated access is uncacheable |

## Verification
Two actions can fall in the same cycle: an insert's duplicate check and its victim choice on a full table. The bench first fills all entries. It then issues an insert to a page that is already present, followed by inserts of new pages. It judges the result by which older page misses afterwards. The stamp refresh of a lookup coincides with that lookup's protection evaluation. Lookups with and without `updateLru` are mixed before an eviction, so the choice of evicted page shows whether the refresh landed. A behavioural model in the bench checks every response cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP      = 3'd0,
    OP_INSERT      = 3'd1,
    OP_FLUSH_ALL   = 3'd2,
    OP_FLUSH_LOCAL = 3'd3,
    OP_DEMAP       = 3'd4
  } tlbOp_e;

  typedef struct packed {
    logic lookupEn;
    logic stampHit;
    logic insertEn;
    logic flushAll;
    logic flushLocal;
    logic demapEn;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             updateLru,
  input  logic             anyMatch,
  output tlbStrobe_t       strobe,
  output logic [SEQ_W-1:0] seqNow
);

  tlbOp_e opKind;

  always_comb begin
    opKind = tlbOp_e'(opCode);
    strobe = '0;
    if (opValid) begin
      case (opKind)
        OP_LOOKUP: begin
          strobe.lookupEn = 1'b1;
          strobe.stampHit = updateLru && anyMatch;
        end
        OP_INSERT:      strobe.insertEn   = !anyMatch;
        OP_FLUSH_ALL:   strobe.flushAll   = 1'b1;
        OP_FLUSH_LOCAL: strobe.flushLocal = 1'b1;
        OP_DEMAP:       strobe.demapEn    = anyMatch;
        default:        strobe = '0;
      endcase
    end
  end

  // sequence counter: every stamp write consumes one value
  always_ff @(posedge clk) begin
    if (!rstN)
      seqNow <= '0;
    else if (strobe.stampHit || strobe.insertEn)
      seqNow <= seqNow + 1'b1;
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int LB_W    = 5,
  parameter int SEQ_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [SEQ_W-1:0] seqNow,
  input  logic [VA_W-1:0]  opVaddr,
  input  logic             accWrite,
  input  logic             storeCheck,
  input  logic [1:0]       privLevel,
  input  logic             forceSuper,
  input  logic             wpEnable,
  input  logic [PA_W-1:0]  insPbase,
  input  logic [LB_W-1:0]  insLogBytes,
  input  logic             insGlobal,
  input  logic             insWritable,
  input  logic             insUser,
  input  logic             insUncache,
  output logic             anyMatch,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic             rspFault,
  output logic             rspFaultWrite,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspUncache
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [VA_W-1:0] VA_ONES = '1;

  logic [ENTRIES-1:0] valid, glob, wrOk, usrOk, uncEn, matchVec;
  logic [VA_W-1:0]    tag   [ENTRIES];
  logic [PA_W-1:0]    pbase [ENTRIES];
  logic [LB_W-1:0]    lb    [ENTRIES];
  logic [SEQ_W-1:0]   stamp [ENTRIES];

  logic [IDX_W-1:0] hitIdx, freeIdx, lruIdx, victimIdx;
  logic             freeFound;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign matchVec[g] = valid[g] && (((opVaddr ^ tag[g]) >> lb[g]) == '0);
  end

  assign anyMatch = |matchVec;

  // lowest matching index wins
  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  // victim: first free slot, else oldest stamp (ties to lowest index)
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!valid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    lruIdx = '0;
    for (int i = 1; i < ENTRIES; i++)
      if (stamp[i] < stamp[lruIdx]) lruIdx = IDX_W'(i);
    victimIdx = freeFound ? freeIdx : lruIdx;
  end

  logic [VA_W-1:0] hitMask, insMask;
  logic [PA_W-1:0] hitPaddr;
  logic            inUser, badWrite, userViol, faultNow, faultAsWr;

  always_comb begin
    hitMask   = ~(VA_ONES << lb[hitIdx]);
    insMask   = ~(VA_ONES << insLogBytes);
    hitPaddr  = pbase[hitIdx] | PA_W'(opVaddr & hitMask);
    inUser    = (privLevel == 2'd3) && !forceSuper;
    badWrite  = !wrOk[hitIdx] && (inUser || wpEnable);
    userViol  = inUser && !usrOk[hitIdx];
    faultNow  = userViol || ((accWrite || storeCheck) && badWrite);
    faultAsWr = faultNow && (accWrite || (!userViol && storeCheck && badWrite));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      glob  <= '0;
      wrOk  <= '0;
      usrOk <= '0;
      uncEn <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i]   <= '0;
        pbase[i] <= '0;
        lb[i]    <= '0;
        stamp[i] <= '0;
      end
    end else begin
      if (strobe.flushAll) begin
        valid <= '0;
      end else if (strobe.flushLocal) begin
        valid <= valid & glob;
      end else if (strobe.demapEn) begin
        valid[hitIdx] <= 1'b0;
      end else if (strobe.insertEn) begin
        valid[victimIdx]  <= 1'b1;
        tag[victimIdx]    <= opVaddr & ~insMask;
        pbase[victimIdx]  <= insPbase;
        lb[victimIdx]     <= insLogBytes;
        glob[victimIdx]   <= insGlobal;
        wrOk[victimIdx]   <= insWritable;
        usrOk[victimIdx]  <= insUser;
        uncEn[victimIdx]  <= insUncache;
        stamp[victimIdx]  <= seqNow;
      end
      if (strobe.stampHit) stamp[hitIdx] <= seqNow;
    end
  end

  logic lookHit;
  assign lookHit = strobe.lookupEn && anyMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspHit        <= 1'b0;
      rspMiss       <= 1'b0;
      rspFault      <= 1'b0;
      rspFaultWrite <= 1'b0;
      rspPaddr      <= '0;
      rspUncache    <= 1'b0;
    end else begin
      rspValid      <= strobe.lookupEn;
      rspHit        <= lookHit;
      rspMiss       <= strobe.lookupEn && !anyMatch;
      rspFault      <= lookHit && faultNow;
      rspFaultWrite <= lookHit && faultAsWr;
      rspPaddr      <= lookHit ? hitPaddr : '0;
      rspUncache    <= lookHit && !faultNow && uncEn[hitIdx];
    end
  end

endmodule

// File: rtl/seq_lru_tlb.sv
module seq_lru_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int LB_W    = 5,
  parameter int SEQ_W   = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic [VA_W-1:0] opVaddr,
  input  logic            updateLru,
  input  logic            accWrite,
  input  logic            storeCheck,
  input  logic [1:0]      privLevel,
  input  logic            forceSuper,
  input  logic            wpEnable,
  input  logic [PA_W-1:0] insPbase,
  input  logic [LB_W-1:0] insLogBytes,
  input  logic            insGlobal,
  input  logic            insWritable,
  input  logic            insUser,
  input  logic            insUncache,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspMiss,
  output logic            rspFault,
  output logic            rspFaultWrite,
  output logic [PA_W-1:0] rspPaddr,
  output logic            rspUncache
);

  tlbStrobe_t       strobe;
  logic [SEQ_W-1:0] seqNow;
  logic             anyMatch;

  tlb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .updateLru(updateLru), .anyMatch(anyMatch),
    .strobe(strobe), .seqNow(seqNow)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .LB_W(LB_W), .SEQ_W(SEQ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seqNow(seqNow),
    .opVaddr(opVaddr), .accWrite(accWrite), .storeCheck(storeCheck),
    .privLevel(privLevel), .forceSuper(forceSuper), .wpEnable(wpEnable),
    .insPbase(insPbase), .insLogBytes(insLogBytes), .insGlobal(insGlobal),
    .insWritable(insWritable), .insUser(insUser), .insUncache(insUncache),
    .anyMatch(anyMatch), .rspValid(rspValid), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspFault(rspFault), .rspFaultWrite(rspFaultWrite),
    .rspPaddr(rspPaddr), .rspUncache(rspUncache)
  );

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [2:0] opCode,
  input logic       rspValid,
  input logic       rspHit,
  input logic       rspMiss,
  input logic       rspFault,
  input logic       rspFaultWrite,
  input logic       rspUncache
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !rspValid && !rspHit && !rspMiss && !rspFault);

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss}) == 1);

  // R2
  answer_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(opValid && opCode == 3'd0));

  // R2
  idle_no_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspHit && !rspMiss);

  // R9
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(opValid && opCode == 3'd2, 2)) |-> rspMiss);

  // R11
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspHit);

  // R12
  write_kind_needs_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFaultWrite |-> rspFault);

  // R13
  uncache_clean_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspUncache |-> rspHit && !rspFault);

endmodule

bind seq_lru_tlb tlb_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
  .rspFault(rspFault), .rspFaultWrite(rspFaultWrite), .rspUncache(rspUncache)
);

// File: tb/test_seq_lru_tlb.sv
module test_seq_lru_tlb;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [31:0] opVaddr = '0;
  logic updateLru = 1'b0, accWrite = 1'b0, storeCheck = 1'b0;
  logic [1:0] privLevel = '0;
  logic forceSuper = 1'b0, wpEnable = 1'b0;
  logic [31:0] insPbase = '0;
  logic [4:0] insLogBytes = '0;
  logic insGlobal = 1'b0, insWritable = 1'b0, insUser = 1'b0, insUncache = 1'b0;
  logic rspValid, rspHit, rspMiss, rspFault, rspFaultWrite, rspUncache;
  logic [31:0] rspPaddr;

  always #2.5 clk = ~clk;

  seq_lru_tlb i_seq_lru_tlb (.*);

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference model
  bit          mV[N], mG[N], mW[N], mU[N], mC[N];
  logic [31:0] mTag[N], mPb[N];
  int          mLb[N];
  int unsigned mSt[N];
  int unsigned mSeq;
  bit          eValid, eHit, eMiss, eFault, eFw, eUnc;
  logic [31:0] ePaddr;

  function automatic bit covers(int i, logic [31:0] va);
    return mV[i] && (((va ^ mTag[i]) >> mLb[i]) == 0);
  endfunction

  always @(posedge clk) begin
    int h;
    eValid = 0; eHit = 0; eMiss = 0; eFault = 0; eFw = 0; eUnc = 0; ePaddr = '0;
    if (!rstN) begin
      mSeq = 0;
      foreach (mV[i]) begin mV[i] = 0; mSt[i] = 0; end
    end else if (opValid) begin
      h = -1;
      for (int i = N - 1; i >= 0; i--) if (covers(i, opVaddr)) h = i;
      case (opCode)
        3'd0: begin
          eValid = 1;
          if (h < 0) eMiss = 1;
          else begin
            bit usr, bad, uv;
            longint m;
            eHit = 1;
            m = (64'd1 << mLb[h]) - 1;
            ePaddr = mPb[h] | (opVaddr & m[31:0]);
            usr = (privLevel == 3) && !forceSuper;
            bad = !mW[h] && (usr || wpEnable);
            uv  = usr && !mU[h];
            eFault = uv || ((accWrite || storeCheck) && bad);
            eFw = eFault && (accWrite || (!uv && storeCheck && bad));
            eUnc = !eFault && mC[h];
            if (updateLru) begin mSt[h] = mSeq; mSeq++; end
          end
        end
        3'd1: if (h < 0) begin
          int v;
          longint m;
          v = -1;
          for (int i = 0; i < N; i++) if (!mV[i] && v < 0) v = i;
          if (v < 0) begin
            v = 0;
            for (int i = 1; i < N; i++) if (mSt[i] < mSt[v]) v = i;
          end
          m = (64'd1 << insLogBytes) - 1;
          mV[v] = 1; mTag[v] = opVaddr & ~m[31:0]; mPb[v] = insPbase;
          mLb[v] = int'(insLogBytes); mG[v] = insGlobal; mW[v] = insWritable;
          mU[v] = insUser; mC[v] = insUncache; mSt[v] = mSeq; mSeq++;
        end
        3'd2: foreach (mV[i]) mV[i] = 0;
        3'd3: foreach (mV[i]) if (!mG[i]) mV[i] = 0;
        3'd4: if (h >= 0) mV[h] = 0;
        default: ;
      endcase
    end
  end

  task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", curReq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("rspValid", 32'(rspValid), 32'(eValid));
    cmp("rspHit", 32'(rspHit), 32'(eHit));
    cmp("rspMiss", 32'(rspMiss), 32'(eMiss));
    cmp("rspFault", 32'(rspFault), 32'(eFault));
    cmp("rspFaultWrite", 32'(rspFaultWrite), 32'(eFw));
    cmp("rspPaddr", rspPaddr, ePaddr);
    cmp("rspUncache", 32'(rspUncache), 32'(eUnc));
  end

  task automatic look(logic [31:0] va, bit upd = 1, bit wr = 0, bit sc = 0,
                      logic [1:0] pl = 0, bit fs = 0, bit wp = 0);
    @(negedge clk);
    opValid = 1; opCode = 3'd0; opVaddr = va; updateLru = upd; accWrite = wr;
    storeCheck = sc; privLevel = pl; forceSuper = fs; wpEnable = wp;
  endtask

  task automatic ins(logic [31:0] va, logic [31:0] pb, logic [4:0] l,
                     bit g, bit w, bit u, bit c);
    @(negedge clk);
    opValid = 1; opCode = 3'd1; opVaddr = va; insPbase = pb; insLogBytes = l;
    insGlobal = g; insWritable = w; insUser = u; insUncache = c;
  endtask

  task automatic ctl(logic [2:0] code, logic [31:0] va = 0);
    @(negedge clk);
    opValid = 1; opCode = code; opVaddr = va;
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    curReq = "R1"; look(32'h1000);
    curReq = "R2"; look(32'h1234); idle();
    curReq = "R7";
    for (int k = 0; k < 8; k++)
      ins((k + 1) << 12, 32'h4000_0000 + (k << 12), 5'd12,
          k < 2, k != 3, k != 5, k == 6);
    curReq = "R4"; look(32'h1010, 1); look(32'h2123, 0);
    curReq = "R5"; ins(32'h3000, 32'h7777_0000, 5'd12, 0, 1, 1, 0);
    look(32'h3456, 0);
    curReq = "R6"; ins(32'h9000, 32'h5000_0000, 5'd12, 0, 1, 1, 0);
    look(32'h2000, 0); look(32'h1000, 0); look(32'h9abc, 0);
    ins(32'hA000, 32'h5100_0000, 5'd12, 0, 1, 1, 0);
    look(32'h3000, 0); look(32'hA00F, 0);
    curReq = "R10"; ctl(3'd4, 32'h5555); look(32'h5000, 0); ctl(3'd4, 32'hF000);
    curReq = "R3"; ins(32'h0065_4321, 32'h8000_0000, 5'd21, 0, 1, 1, 0);
    look(32'h007A_BCDE); look(32'h0080_0000); look(32'h0060_0000);
    curReq = "R11";
    look(32'h6000, 1, 0, 0, 2'd3, 0, 0);
    look(32'h6000, 1, 0, 0, 2'd3, 1, 0);
    look(32'h6000, 1, 0, 0, 2'd0, 0, 0);
    look(32'h6000, 1, 1, 0, 2'd3, 0, 0);
    curReq = "R12";
    look(32'h4000, 1, 1, 0, 2'd0, 0, 0);
    look(32'h4000, 1, 1, 0, 2'd0, 0, 1);
    look(32'h4000, 1, 1, 0, 2'd3, 0, 0);
    look(32'h4000, 1, 0, 1, 2'd3, 0, 0);
    look(32'h4000, 1, 0, 0, 2'd3, 0, 0);
    look(32'h4000, 1, 0, 1, 2'd3, 1, 0);
    look(32'h6000, 1, 0, 1, 2'd3, 0, 0);
    curReq = "R13"; look(32'h7abc); look(32'h7abc, 1, 1, 0, 2'd3, 0, 1); idle();
    curReq = "R8"; ctl(3'd3); look(32'h1000); look(32'h7000); look(32'h9000);
    curReq = "R9"; ins(32'h2000, 32'h6000_0000, 5'd12, 1, 1, 1, 0);
    look(32'h2000); ctl(3'd2); look(32'h2000); look(32'h1000); idle(); idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule